// File: doc/BRIEF.md
# ADC Ramp Pattern Checker

This block watches a single converter channel while the converter is driving a known incrementing test ramp. It idles in an unlocked state until a valid sample of value zero arrives, then locks. From the lock point it predicts every following valid sample as the previous valid sample plus one, wrapping at the top of the sample range, and raises an error flag on the first deviation.

The locked and error outputs are separate, so host software reading them can tell a channel that never found the ramp apart from one that found it and then saw bit errors. The error flag is sticky. Dropping the enable input clears both flags and the stored sample, so toggling enable restarts a measurement. One instance serves one channel. A radio with an I and a Q channel uses two instances, fed from the two left-aligned 14-bit fields of the packed 32-bit word (I in bits 31:18, Q in bits 15:2).

Top module: `adc_ramp_checker`

## Requirements
- R1: After reset is released, `locked` and `rampError` are both 0.
- R2: While unlocked, `locked` stays 0 unless a valid sample equal to 0 is presented, and `rampError` cannot become 1.
- R3: A valid sample equal to 0, presented while enabled and unlocked, sets `locked` on the next clock edge.
- R4: Once locked, a valid sample that differs from the previous valid sample plus one (modulo 2^SAMPLE_W) sets `rampError` on the next clock edge. The comparison always uses the previous valid sample, so after a corrupted sample the sample that follows it is compared against corrupted+1.
- R5: A step from 0x3FFF to 0x0000 (all ones to zero for SAMPLE_W=14) counts as a correct ramp step and raises no error.
- R6: Once set, `rampError` stays 1 for as long as `enable` stays high.
- R7: With `enable` low, both flags read 0 after the next clock edge. After `enable` returns high, lock is acquired only by a new zero sample.
- R8: Cycles with `sampleValid` low are ignored. They do not lock, do not raise an error and do not replace the stored previous sample.
- R9: Once set, `locked` stays 1 for as long as `enable` stays high, even across errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checker enable; low clears all state |
| sampleValid | input | 1 | Qualifies `sample` in this cycle |
| sample | input | SAMPLE_W | Channel sample, right-aligned |
| locked | output | 1 | Ramp start (zero) has been seen |
| rampError | output | 1 | Sticky ramp-mismatch indication |

## Verification
A stored previous sample that has been corrupted shows up as a spurious `rampError` one edge after the next valid sample, or as a missed error on a real glitch. A controller state that is stuck or lost shows as `locked` failing to rise one edge after a zero sample, or falling while enabled. A missed clear shows as a flag that is still set one edge after `enable` drops. The bench runs a full wrap of the sample range and a random stream with gaps, glitches and restarts. Because of that, each of these faults becomes visible within one to two cycles of the stimulus that exposes it.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;

  typedef enum logic [0:0] {
    ST_SEEK  = 1'b0,
    ST_TRACK = 1'b1
  } rampState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // wipe stored sample and error
    logic capture;  // load the current sample as the new reference
    logic compare;  // judge current sample against reference+1
  } rampStrobes_t;

endpackage

// File: rtl/adc_ramp_ctrl.sv
module adc_ramp_ctrl
  import adc_ramp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         sampleValid,
  input  logic         sampleIsZero,
  output rampStrobes_t strobes,
  output logic         locked
);

  rampState_t stateQ, stateD;
  logic       acceptSample;

  assign acceptSample = enable && sampleValid;

  always_comb begin
    stateD = stateQ;
    if (!enable) begin
      stateD = ST_SEEK;
    end else if (stateQ == ST_SEEK && sampleValid && sampleIsZero) begin
      stateD = ST_TRACK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_SEEK;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    strobes.clear   = !enable;
    strobes.compare = acceptSample && (stateQ == ST_TRACK);
    strobes.capture = acceptSample && ((stateQ == ST_TRACK) || sampleIsZero);
  end

  assign locked = (stateQ == ST_TRACK);

endmodule

// File: rtl/adc_ramp_datapath.sv
module adc_ramp_datapath
  import adc_ramp_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rampStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sampleIsZero,
  output logic                rampError
);

  localparam logic [SAMPLE_W-1:0] STEP = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] prevQ;
  logic [SAMPLE_W-1:0] expected;
  logic                mismatch;
  logic                errQ;

  assign sampleIsZero = (sample == '0);
  assign expected     = prevQ + STEP;  // wraps naturally at 2^SAMPLE_W
  assign mismatch     = strobes.compare && (sample != expected);

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clear) begin
      prevQ <= '0;
    end else if (strobes.capture) begin
      prevQ <= sample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clear) begin
      errQ <= 1'b0;
    end else if (mismatch) begin
      errQ <= 1'b1;
    end
  end

  assign rampError = errQ;

endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker
  import adc_ramp_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                locked,
  output logic                rampError
);

  rampStrobes_t strobes;
  logic         sampleIsZero;

  adc_ramp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sampleValid  (sampleValid),
    .sampleIsZero (sampleIsZero),
    .strobes      (strobes),
    .locked       (locked)
  );

  adc_ramp_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .sample       (sample),
    .sampleIsZero (sampleIsZero),
    .rampError    (rampError)
  );

endmodule

// File: rtl/adc_ramp_checker_sva.sv
module adc_ramp_checker_sva #(
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sample,
  input logic                locked,
  input logic                rampError
);

  localparam logic [SAMPLE_W-1:0] STEP = SAMPLE_W'(1);

  // independent record of the last valid sample seen while enabled
  logic [SAMPLE_W-1:0] lastSeen;
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) lastSeen <= '0;
    else if (sampleValid)  lastSeen <= sample;
  end

  p_clear_on_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!locked && !rampError));

  p_no_error_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !rampError) |=> !rampError);

  p_lock_only_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !(enable && sampleValid && sample == '0)) |=> !locked);

  p_lock_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleValid && !locked && sample == '0) |=> locked);

  p_flag_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && locked && sampleValid && sample != lastSeen + STEP) |=> rampError);

  p_error_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rampError) |=> rampError);

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && locked) |=> locked);

endmodule

bind adc_ramp_checker adc_ramp_checker_sva #(.SAMPLE_W(SAMPLE_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .sampleValid (sampleValid),
  .sample      (sample),
  .locked      (locked),
  .rampError   (rampError)
);

// File: tb/adc_ramp_checker_test.sv
module adc_ramp_checker_test;

  localparam int SAMPLE_W = 14;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = (1 << SAMPLE_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                enable = 1'b0;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sample = '0;
  logic                locked;
  logic                rampError;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit                  mLock = 0;
  bit                  mErr  = 0;
  logic [SAMPLE_W-1:0] mPrev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ramp_checker #(.SAMPLE_W(SAMPLE_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sampleValid(sampleValid),
    .sample(sample), .locked(locked), .rampError(rampError)
  );

  function automatic logic [SAMPLE_W-1:0] nextRamp(logic [SAMPLE_W-1:0] v);
    return v + SAMPLE_W'(1);
  endfunction

  task automatic check(string req, bit expLock, bit expErr);
    checks++;
    if (locked !== expLock || rampError !== expErr) begin
      fails++;
      $display("FAIL %s: locked/error got %0b/%0b expected %0b/%0b at %0t",
               req, locked, rampError, expLock, expErr, $time);
    end
  endtask

  // drive one cycle, then update the model after the edge
  task automatic step(bit en, bit v, logic [SAMPLE_W-1:0] s);
    @(negedge clk);
    enable = en; sampleValid = v; sample = s;
    @(posedge clk);
    #1;
    if (!en) begin
      mLock = 0; mErr = 0; mPrev = '0;
    end else if (v) begin
      if (!mLock) begin
        if (s == '0) begin mLock = 1; mPrev = s; end
      end else begin
        if (s != nextRamp(mPrev)) mErr = 1;
        mPrev = s;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 0, 0);

    // ramp starting at nonzero value never locks
    for (int i = 5; i < 40; i++) step(1, 1, SAMPLE_W'(i));
    check("R2", 0, 0);

    // zero without valid is ignored
    step(1, 0, '0);
    check("R8", 0, 0);

    // zero locks
    step(1, 1, '0);
    check("R3", 1, 0);

    // clean ramp
    for (int i = 1; i < 60; i++) step(1, 1, SAMPLE_W'(i));
    check("R4", 1, 0);

    // invalid garbage in the middle is ignored, ramp continues
    step(1, 0, SAMPLE_W'(999));
    step(1, 0, SAMPLE_W'(3));
    check("R8", 1, 0);
    step(1, 1, SAMPLE_W'(60));
    check("R8", 1, 0);

    // full wrap through all ones to zero
    for (int i = 61; i <= TOP; i++) step(1, 1, SAMPLE_W'(i));
    check("R5", 1, 0);
    step(1, 1, '0);
    check("R5", 1, 0);
    step(1, 1, SAMPLE_W'(1));
    check("R5", 1, 0);

    // single corrupted sample
    step(1, 1, SAMPLE_W'(2));
    step(1, 1, SAMPLE_W'(7));
    check("R4", 1, 1);
    for (int i = 4; i < 30; i++) step(1, 1, SAMPLE_W'(i));
    check("R6", 1, 1);
    check("R9", 1, 1);

    // disable clears, re-enable needs a new zero
    step(0, 1, SAMPLE_W'(30));
    check("R7", 0, 0);
    step(1, 1, SAMPLE_W'(31));
    step(1, 1, SAMPLE_W'(32));
    check("R7", 0, 0);
    step(1, 1, '0);
    check("R7", 1, 0);

    // random phase: ramp with gaps, glitches and restarts
    begin
      logic [SAMPLE_W-1:0] cur;
      cur = '0;
      for (int n = 0; n < 20000; n++) begin
        bit en, v;
        logic [SAMPLE_W-1:0] s;
        en = ($urandom % 300) != 0;
        v  = ($urandom % 4) != 0;
        if (($urandom % 500) == 0) cur = SAMPLE_W'($urandom);
        s = cur;
        if (v && ($urandom % 256) == 0) s = SAMPLE_W'($urandom);
        step(en, v, s);
        if (v) cur = nextRamp(cur);
        if ((n % 16) == 0) check("R4", mLock, mErr);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule